// File: doc/BRIEF.md
# Timer Register Bank with Key-Gated Write Protection

This block holds the configuration and compare registers of a multi-channel timer, behind a plain register write port and a plain read port. Software can lock these registers against stray writes. While the lock is engaged, any write aimed at a locked register is dropped without a bus error, and the register keeps its value. The lock lives in a separate lock-control register. A write to that register takes effect only when the upper 24 bits of the write word carry the ASCII code "TIM" (0x54494D). A write with any other upper field is thrown away.

A status register shows whether the lock is engaged. It also records that a write was dropped and which word address that write targeted. The record stays until software reads the status register. One unlocked scratch register and the lock-control and status registers are never locked. The counting datapath, interrupts and bus error responses are not part of this block.

Top module: `wp_regbank`

## Requirements
- R1: After reset the lock is off, every lockable register reads zero, and the status register reads zero.
- R2: While the lock is off, a write (`wr_en` high for one cycle) to a lockable register stores all 32 bits of `wr_data`. The new value is visible on `rd_data` from the next cycle.
- R3: While the lock is on, a write to a lockable register is cancelled and the register keeps its previous contents.
- R4: The lockable set is exactly this list of word addresses: block mode at 0x00, fault mode at 0x01, and for channel c (0 to NCH-1) mode at 0x08+8c, secondary mode at 0x09+8c, and compare A, B and C at 0x0A+8c, 0x0B+8c and 0x0C+8c.
- R5: A write to the lock-control register (address 0x02) whose bits 31:8 equal 0x54494D sets the lock to bit 0 of the write. Reading address 0x02 returns the lock state in bit 0 and zeros in all other bits.
- R6: A write to address 0x02 whose bits 31:8 differ from 0x54494D leaves the lock state unchanged.
- R7: The scratch register at 0x04 accepts writes whether the lock is on or off. Reads of every register do not depend on the lock state.
- R8: A cancelled write sets the violation flag (status bit 1) and records its word address in status bits 8+ADDR_W-1:8. While the flag is set, later cancelled writes do not replace the recorded address.
- R9: Reading the status register (address 0x03) returns its value before the read and clears the violation flag afterwards. If a cancelled write lands in the same cycle as the read, the flag stays set and that write's address is recorded.
- R10: Writes to the status register or to unmapped addresses have no effect, and reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe (needed for the status clear-on-read) |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| prot_on | output | 1 | Current lock state |

## Verification
The port takes at most one write and one read per cycle and applies no back-pressure. The assertions therefore assume that every cycle with `wr_en` high is a finished write, and that a `rd_en` pulse on the status address is a real read that should clear the flag. The assertions also assume that `wr_addr` fits in ADDR_W bits and that the write data is fully driven while the strobe is high. The bench drives each strobe for exactly one cycle, with stable address and data, changing them only just after a rising edge. It covers a combined write-and-read cycle so that the case where the set and the clear of the flag meet is checked.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int DATA_W      = 32;
  localparam logic [23:0] UNLOCK_KEY = 24'h54494D;
  localparam int A_BLKMODE   = 0;
  localparam int A_FAULT     = 1;
  localparam int A_LOCKCTL   = 2;
  localparam int A_STATUS    = 3;
  localparam int A_SCRATCH   = 4;
  localparam int CH_BASE     = 8;
  localparam int CH_STRIDE   = 8;
  localparam int CH_REGS     = 5;
  localparam int GLOBAL_REGS = 2;
  localparam int STAT_ADDR_LSB = 8;
endpackage

// File: rtl/wp_decode.sv
module wp_decode
  import wp_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NCH    = 3,
  parameter int NPROT  = GLOBAL_REGS + CH_REGS * NCH,
  parameter int IDX_W  = $clog2(NPROT)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              prot_hit,
  output logic [IDX_W-1:0]  prot_idx,
  output logic              lock_hit,
  output logic              stat_hit,
  output logic              scr_hit
);
  localparam int OFF_W = $clog2(CH_STRIDE);

  logic [ADDR_W-1:0] rel;
  logic [ADDR_W-1:0] chan;
  logic [OFF_W-1:0]  off;
  logic              in_chan;

  always_comb begin
    rel     = addr - ADDR_W'(CH_BASE);
    chan    = rel >> OFF_W;
    off     = rel[OFF_W-1:0];
    in_chan = (addr >= ADDR_W'(CH_BASE)) && (chan < ADDR_W'(NCH)) &&
              (off < OFF_W'(CH_REGS));
    lock_hit = (addr == ADDR_W'(A_LOCKCTL));
    stat_hit = (addr == ADDR_W'(A_STATUS));
    scr_hit  = (addr == ADDR_W'(A_SCRATCH));
    prot_hit = 1'b0;
    prot_idx = '0;
    if (addr == ADDR_W'(A_BLKMODE)) begin
      prot_hit = 1'b1;
      prot_idx = IDX_W'(0);
    end else if (addr == ADDR_W'(A_FAULT)) begin
      prot_hit = 1'b1;
      prot_idx = IDX_W'(1);
    end else if (in_chan) begin
      prot_hit = 1'b1;
      prot_idx = IDX_W'(GLOBAL_REGS + CH_REGS * int'(chan) + int'(off));
    end
  end
endmodule

// File: rtl/wp_key_gate.sv
module wp_key_gate
  import wp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lock_wr,
  input  logic [23:0] key,
  input  logic        en_bit,
  output logic        prot_on
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      prot_on <= 1'b0;
    else if (lock_wr && (key == UNLOCK_KEY))
      prot_on <= en_bit;
  end
endmodule

// File: rtl/wp_viol_track.sv
module wp_viol_track #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic              clr,
  output logic              viol,
  output logic [ADDR_W-1:0] viol_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol      <= 1'b0;
      viol_addr <= '0;
    end else if (set) begin
      viol <= 1'b1;
      if (!viol || clr) viol_addr <= set_addr;
    end else if (clr) begin
      viol      <= 1'b0;
      viol_addr <= '0;
    end
  end
endmodule

// File: rtl/wp_regbank.sv
module wp_regbank
  import wp_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NCH    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              prot_on
);
  localparam int NPROT = GLOBAL_REGS + CH_REGS * NCH;
  localparam int IDX_W = $clog2(NPROT);

  logic             w_prot, w_lock, w_stat, w_scr;
  logic [IDX_W-1:0] w_idx;
  logic             r_prot, r_lock, r_stat, r_scr;
  logic [IDX_W-1:0] r_idx;
  logic             viol;
  logic [ADDR_W-1:0] viol_addr;
  logic             cancel;
  logic [NPROT-1:0] reg_we;
  logic [DATA_W-1:0] prot_q [NPROT];
  logic [DATA_W-1:0] scr_q;

  wp_decode #(.ADDR_W(ADDR_W), .NCH(NCH)) wdec_i (
    .addr(wr_addr), .prot_hit(w_prot), .prot_idx(w_idx),
    .lock_hit(w_lock), .stat_hit(w_stat), .scr_hit(w_scr)
  );

  wp_decode #(.ADDR_W(ADDR_W), .NCH(NCH)) rdec_i (
    .addr(rd_addr), .prot_hit(r_prot), .prot_idx(r_idx),
    .lock_hit(r_lock), .stat_hit(r_stat), .scr_hit(r_scr)
  );

  wp_key_gate key_i (
    .clk(clk), .rst_n(rst_n),
    .lock_wr(wr_en && w_lock), .key(wr_data[31:8]), .en_bit(wr_data[0]),
    .prot_on(prot_on)
  );

  assign cancel = wr_en && w_prot && prot_on;

  wp_viol_track #(.ADDR_W(ADDR_W)) viol_i (
    .clk(clk), .rst_n(rst_n),
    .set(cancel), .set_addr(wr_addr),
    .clr(rd_en && r_stat),
    .viol(viol), .viol_addr(viol_addr)
  );

  for (genvar g = 0; g < NPROT; g++) begin : g_we
    assign reg_we[g] = wr_en && w_prot && !prot_on && (w_idx == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPROT; i++) prot_q[i] <= '0;
      scr_q <= '0;
    end else begin
      for (int i = 0; i < NPROT; i++)
        if (reg_we[i]) prot_q[i] <= wr_data;
      if (wr_en && w_scr) scr_q <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (r_prot) begin
      rd_data = prot_q[r_idx];
    end else if (r_scr) begin
      rd_data = scr_q;
    end else if (r_lock) begin
      rd_data[0] = prot_on;
    end else if (r_stat) begin
      rd_data[0] = prot_on;
      rd_data[1] = viol;
      rd_data[STAT_ADDR_LSB +: ADDR_W] = viol_addr;
    end
  end
endmodule

// File: rtl/wp_regbank_chk.sv
module wp_regbank_chk
  import wp_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NCH    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [23:0]       wr_key,
  input logic              wr_bit0,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              prot_on,
  input logic              viol,
  input logic [ADDR_W-1:0] viol_addr
);
  function automatic logic lockable(input logic [ADDR_W-1:0] a);
    int ai;
    ai = int'(a);
    if (ai == A_BLKMODE || ai == A_FAULT) return 1'b1;
    if (ai < CH_BASE) return 1'b0;
    return ((ai - CH_BASE) / CH_STRIDE < NCH) && ((ai - CH_BASE) % CH_STRIDE < CH_REGS);
  endfunction

  logic key_wr, cancel_wr, stat_rd;
  assign key_wr    = wr_en && (wr_addr == ADDR_W'(A_LOCKCTL));
  assign cancel_wr = wr_en && prot_on && lockable(wr_addr);
  assign stat_rd   = rd_en && (rd_addr == ADDR_W'(A_STATUS));

  assert_key_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr && (wr_key == UNLOCK_KEY) |=> prot_on == $past(wr_bit0));

  assert_bad_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr && (wr_key != UNLOCK_KEY) |=> $stable(prot_on));

  assert_lock_only_by_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr |=> $stable(prot_on));

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_wr |=> viol);

  assert_addr_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_wr && (!viol || stat_rd) |=> viol_addr == $past(wr_addr));

  assert_first_addr_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    viol && !stat_rd |=> viol && $stable(viol_addr));

  assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !cancel_wr |=> !viol);
endmodule

bind wp_regbank wp_regbank_chk #(.ADDR_W(ADDR_W), .NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_key(wr_data[31:8]), .wr_bit0(wr_data[0]),
  .rd_en(rd_en), .rd_addr(rd_addr),
  .prot_on(prot_on), .viol(viol), .viol_addr(viol_addr)
);

// File: tb/wp_regbank_tb_top.sv
`timescale 1ns/1ps
module wp_regbank_tb_top;
  localparam int AW  = 6;
  localparam int NCH = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0]   rd_data;
  logic          prot_on;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] exp; logic [AW-1:0] addr; string req; } item_t;
  item_t sb[$];

  logic [31:0]   model [64];
  logic          m_prot = 1'b0;
  logic          m_viol = 1'b0;
  logic [AW-1:0] m_vaddr = '0;

  always #2 clk = ~clk;

  wp_regbank #(.ADDR_W(AW), .NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .prot_on(prot_on)
  );

  function automatic bit lockable(input int a);
    if (a == 0 || a == 1) return 1'b1;
    if (a < 8) return 1'b0;
    return ((a - 8) / 8 < NCH) && ((a - 8) % 8 < 5);
  endfunction

  function automatic logic [31:0] expect_rd(input int a);
    logic [31:0] v;
    v = '0;
    if (lockable(a) || a == 4) v = model[a];
    else if (a == 2) v[0] = m_prot;
    else if (a == 3) begin
      v[0] = m_prot; v[1] = m_viol; v[8 +: AW] = m_vaddr;
    end
    return v;
  endfunction

  function automatic void apply_wr(input int a, input logic [31:0] d);
    if (lockable(a)) begin
      if (m_prot) begin
        if (!m_viol) m_vaddr = AW'(a);
        m_viol = 1'b1;
      end else model[a] = d;
    end else if (a == 4) model[a] = d;
    else if (a == 2 && d[31:8] == 24'h54494D) m_prot = d[0];
  endfunction

  task automatic push_rd(input int a, input string req);
    item_t it;
    it.exp = expect_rd(a); it.addr = AW'(a); it.req = req;
    sb.push_back(it);
    if (a == 3) begin m_viol = 1'b0; m_vaddr = '0; end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; rd_en = 1'b0;
    apply_wr(a, d);
  endtask

  task automatic rd(input int a, input string req);
    @(posedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b1; rd_addr = AW'(a);
    push_rd(a, req);
  endtask

  task automatic wr_rd(input int wa, input logic [31:0] d, input int ra, input string req);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = AW'(wa); wr_data = d;
    rd_en = 1'b1; rd_addr = AW'(ra);
    push_rd(ra, req);
    apply_wr(wa, d);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  // monitor: pops one expected item per read strobe, away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      if (rd_en && rst_n) begin
        if (sb.size() == 0) begin
          errors++; checks++;
          $display("FAIL scoreboard empty: read at %0h with no expected item", rd_addr);
        end else begin
          item_t it;
          it = sb.pop_front();
          checks++;
          if (rd_data !== it.exp) begin
            errors++;
            $display("FAIL %s addr=%0h actual=%08h expected=%08h", it.req, it.addr, rd_data, it.exp);
          end
        end
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    rd(0, "R1"); rd(1, "R1"); rd(8 + 8*2 + 4, "R1"); rd(2, "R1"); rd(3, "R1");

    // R2, R4: every lockable address stores data while unlocked
    for (int a = 0; a < 64; a++) if (lockable(a)) wr(a, 32'hA500_0000 | a);
    for (int a = 0; a < 64; a++) if (lockable(a)) rd(a, "R2_R4");
    wr(8 + 5, 32'hFFFF_FFFF); rd(8 + 5, "R4_gap");       // offset 5 is not lockable
    // R10: status and unmapped writes ignored
    wr(3, 32'hFFFF_FFFF); rd(3, "R10");
    wr(7, 32'h1234_5678); rd(7, "R10");
    wr(8 + 8*NCH, 32'h0BAD_0BAD); rd(8 + 8*NCH, "R10");
    // R7: scratch
    wr(4, 32'hCAFE_0001); rd(4, "R7");

    // R6: wrong keys do not engage the lock
    wr(2, 32'h5449_4E01); rd(2, "R6");
    wr(2, 32'h0000_0001); rd(2, "R6");
    wr(0, 32'h0000_1111); rd(0, "R6_still_writable");

    // R5: correct key engages the lock
    wr(2, 32'h5449_4D01); rd(2, "R5"); rd(3, "R5_status");

    // R3, R8: cancelled writes
    wr(9, 32'hDEAD_0009); rd(9, "R3");
    rd(3, "R8_capture");
    wr(1, 32'hDEAD_0001); wr(8 + 8 + 2, 32'hDEAD_0002); wr(8 + 8*2 + 4, 32'hDEAD_0003);
    rd(1, "R3"); rd(8 + 8 + 2, "R3"); rd(8 + 8*2 + 4, "R3");
    rd(3, "R8_first_kept");
    rd(3, "R9_cleared");

    // R9: cancelled write in the same cycle as a status read
    wr(0, 32'hDEAD_0000);
    wr_rd(8 + 3, 32'hDEAD_000B, 3, "R9_old_value");
    rd(3, "R9_set_wins");
    rd(3, "R9_cleared_again");

    // R7: scratch and reads unaffected while locked
    wr(4, 32'hCAFE_0002); rd(4, "R7_locked"); rd(8 + 1, "R7_read_locked");

    // R6: wrong key does not release the lock
    wr(2, 32'h0000_0000); rd(2, "R6_release");
    wr(0, 32'h0000_2222); rd(0, "R6_locked");
    // R5: correct key releases
    wr(2, 32'h5449_4D00); rd(2, "R5_release");
    wr(0, 32'h0000_3333); rd(0, "R5_writable");
    rd(3, "R8_clean");

    idle(); idle(); idle();
    if (sb.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", sb.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule